// File: doc/BRIEF.md
# Dot-Product Load-Store Processor

This block is a small 8-bit multi-cycle processor that runs a stored program from an instruction ROM and exchanges data with a separate data RAM. Its job is to form the dot product of two 2-D vectors with 4-bit coefficients. The main program loads the four coefficients. It calls one multiply subroutine twice and adds the two products in the main flow. It writes the sum back to RAM and then halts.

The core has four program-addressable registers, a program counter and a stack pointer. The stack lives in the data RAM and grows downward from 0xFF. Every instruction is fetched, optionally extended by an address byte, and executed in a fixed number of cycles. When the program reaches its halt instruction the core raises `done` and stops.

Top module: `dotcpu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core returns to ROM address 0, the stack pointer to 0xFF and every register to 0. During reset `rom_addr` reads 0 and `ram_we` and `done` are low.
- R2: An instruction byte holds the opcode in bits [7:4], register A in bits [3:2] and register B in bits [1:0]. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 multiply, 5 push, 6 pop, 7 call and 8 return. Load, store and call take a second byte that carries a RAM address or a ROM target.
- R3: Load copies RAM[address byte] into register A. Store writes register A to RAM[address byte].
- R4: Multiply sets register A to the 8-bit product of the low nibbles of registers A and B. The upper nibbles have no effect.
- R5: Add sets register A to A + B modulo 256.
- R6: Push writes register A to RAM[SP] and then decrements SP. Pop increments SP and then loads RAM[SP] into register A, so the stack returns values in last-in first-out order.
- R7: Call pushes the ROM address of the byte after the call and jumps to the target. Return pops that address back into the PC.
- R8: A one-byte instruction takes 2 clock cycles and a two-byte instruction takes 3.
- R9: After a halt has executed, `done` stays high and the PC (`rom_addr`) stays frozen at the address after the halt byte. No RAM write occurs.
- R10: Opcodes 9 to 15 act as one-byte no-ops: they write nothing and change no register.
- R11: The dot-product program leaves a1*a2 + b1*b2 at RAM address 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 8 | Program counter, used as the instruction ROM address |
| rom_data | input | 8 | Instruction ROM byte at `rom_addr` (combinational read) |
| ram_addr | output | 8 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data |
| ram_we | output | 1 | Data RAM write enable, sampled at the rising edge |
| ram_rdata | input | 8 | Data RAM byte at `ram_addr` (combinational read) |
| done | output | 1 | High once a halt instruction has executed |

## Verification
The bench follows every RAM write in order. This catches a call that links the wrong return address or a push and pop that disagree on whether SP moves before or after the access. Either fault scrambles the stack bytes or the recovered product. Coefficients with nonzero upper nibbles expose a multiplier that uses full bytes. An add that overflows exposes a carry leaking into the result. Cycle counts up to `done` catch a sequencer that adds or skips a phase. An undefined opcode placed mid-program and a watch held over several cycles after halt show whether a no-op changes state and whether a halted core keeps stepping or writing.

// File: rtl/dotcpu_pkg.sv
// Package: shared opcodes, sequencer states and decode helpers for the
// dot-product core. Assumes a 4-bit opcode in the top nibble of the byte.
package dotcpu_pkg;

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_LOAD  = 4'd1;
    localparam logic [3:0] OP_STORE = 4'd2;
    localparam logic [3:0] OP_ADD   = 4'd3;
    localparam logic [3:0] OP_MUL   = 4'd4;
    localparam logic [3:0] OP_PUSH  = 4'd5;
    localparam logic [3:0] OP_POP   = 4'd6;
    localparam logic [3:0] OP_CALL  = 4'd7;
    localparam logic [3:0] OP_RET   = 4'd8;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_OPND  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_HALT  = 2'd3
    } seq_state_e;

    // True for opcodes that carry an address byte after the instruction.
    function automatic logic needs_operand(input logic [3:0] op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_CALL);
    endfunction

endpackage

// File: rtl/dotcpu_regfile.sv
// Register bank: NREG registers of DW bits, one write port and two
// combinational read ports. Assumes synchronous active-low reset to zero.
module dotcpu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RIDX-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [RIDX-1:0] rd_a_idx,
    input  logic [RIDX-1:0] rd_b_idx,
    output logic [DW-1:0]   rd_a,
    output logic [DW-1:0]   rd_b
);

    logic [NREG-1:0][DW-1:0] bank;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;

        // Hold one register; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == RIDX'(g)))
                q <= wr_data;
        end

        assign bank[g] = q;
    end

    assign rd_a = bank[rd_a_idx];
    assign rd_b = bank[rd_b_idx];

endmodule

// File: rtl/dotcpu_alu.sv
// Arithmetic unit: full-width add and a half-width by half-width multiply.
// Assumes DW is even; other opcodes pass operand A through.
module dotcpu_alu
    import dotcpu_pkg::*;
#(
    parameter int DW = 8,
    localparam int NIB = DW / 2
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    logic [DW-1:0] a_lo;
    logic [DW-1:0] b_lo;

    assign a_lo = {{(DW-NIB){1'b0}}, a[NIB-1:0]};
    assign b_lo = {{(DW-NIB){1'b0}}, b[NIB-1:0]};

    // Select the arithmetic result for the current opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_MUL:  y = a_lo * b_lo;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/dotcpu_ctrl.sv
// Sequencer: fetch, optional operand fetch and execute phases. Owns PC,
// SP, the instruction and operand latches, and drives the RAM port and
// the register write port. Assumes AW == DW so PC values fit a data byte.
module dotcpu_ctrl
    import dotcpu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 8,
    parameter int RIDX = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   rom_data,
    input  logic [DW-1:0]   ram_rdata,
    input  logic [DW-1:0]   reg_a,
    input  logic [DW-1:0]   alu_y,
    output logic [AW-1:0]   pc,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    output logic            ram_we,
    output logic            reg_we,
    output logic [DW-1:0]   reg_wdata,
    output logic [RIDX-1:0] ra_idx,
    output logic [RIDX-1:0] rb_idx,
    output logic [3:0]      op,
    output logic            done
);

    localparam logic [AW-1:0] ONE_A = AW'(1);

    seq_state_e      state;
    logic [DW-1:0]   ir;
    logic [AW-1:0]   opnd;
    logic [AW-1:0]   sp;
    logic [AW-1:0]   sp_up;
    logic            in_exec;

    assign op      = ir[DW-1 -: 4];
    assign ra_idx  = ir[2*RIDX-1:RIDX];
    assign rb_idx  = ir[RIDX-1:0];
    assign sp_up   = sp + ONE_A;
    assign in_exec = (state == ST_EXEC);
    assign done    = (state == ST_HALT);

    // Advance the phase sequencer and update PC, SP and the latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
            opnd  <= '0;
            sp    <= '1;
        end else begin
            case (state)
                ST_FETCH: begin
                    ir    <= rom_data;
                    pc    <= pc + ONE_A;
                    state <= needs_operand(rom_data[DW-1 -: 4]) ? ST_OPND : ST_EXEC;
                end
                ST_OPND: begin
                    opnd  <= rom_data[AW-1:0];
                    pc    <= pc + ONE_A;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    case (op)
                        OP_HALT: state <= ST_HALT;
                        OP_PUSH: sp <= sp - ONE_A;
                        OP_POP:  sp <= sp_up;
                        OP_CALL: begin
                            sp <= sp - ONE_A;
                            pc <= opnd;
                        end
                        OP_RET: begin
                            sp <= sp_up;
                            pc <= ram_rdata[AW-1:0];
                        end
                        default: ;
                    endcase
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Drive the RAM port and register write port during execute.
    always_comb begin
        ram_addr  = sp;
        ram_wdata = '0;
        ram_we    = 1'b0;
        reg_we    = 1'b0;
        reg_wdata = alu_y;
        if (in_exec) begin
            case (op)
                OP_LOAD: begin
                    ram_addr  = opnd;
                    reg_we    = 1'b1;
                    reg_wdata = ram_rdata;
                end
                OP_STORE: begin
                    ram_addr  = opnd;
                    ram_wdata = reg_a;
                    ram_we    = 1'b1;
                end
                OP_ADD, OP_MUL: reg_we = 1'b1;
                OP_PUSH: begin
                    ram_wdata = reg_a;
                    ram_we    = 1'b1;
                end
                OP_POP: begin
                    ram_addr  = sp_up;
                    reg_we    = 1'b1;
                    reg_wdata = ram_rdata;
                end
                OP_CALL: begin
                    ram_wdata = DW'(pc);
                    ram_we    = 1'b1;
                end
                OP_RET: ram_addr = sp_up;
                default: ;
            endcase
        end
    end

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + ONE_A)); // R8
    AST_OPND_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPND) |=> (state == ST_EXEC)); // R8
    AST_CALL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == OP_CALL) |=> (pc == $past(opnd))); // R7
    AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && op == OP_PUSH) |=> (sp == $past(sp) - ONE_A)); // R6
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> ($stable(pc) && state == ST_HALT)); // R9

endmodule

// File: rtl/dotcpu_top.sv
// Dot-product core top: joins sequencer, register bank and ALU. Assumes
// an external ROM and RAM, both with combinational reads and the RAM
// written at the rising edge.
module dotcpu_top
    import dotcpu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 8,
    parameter int NREG = 4,
    localparam int RIDX    = $clog2(NREG),
    localparam int NIB     = DW / 2,
    localparam int MUL_MAX = ((2**NIB) - 1) * ((2**NIB) - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    input  logic [DW-1:0] ram_rdata,
    output logic          done
);

    logic [DW-1:0]   reg_a;
    logic [DW-1:0]   reg_b;
    logic [DW-1:0]   alu_y;
    logic            reg_we;
    logic [DW-1:0]   reg_wdata;
    logic [RIDX-1:0] ra_idx;
    logic [RIDX-1:0] rb_idx;
    logic [3:0]      op;

    dotcpu_ctrl #(.DW(DW), .AW(AW), .RIDX(RIDX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rom_data  (rom_data),
        .ram_rdata (ram_rdata),
        .reg_a     (reg_a),
        .alu_y     (alu_y),
        .pc        (rom_addr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ra_idx    (ra_idx),
        .rb_idx    (rb_idx),
        .op        (op),
        .done      (done)
    );

    dotcpu_regfile #(.DW(DW), .NREG(NREG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_idx   (ra_idx),
        .wr_data  (reg_wdata),
        .rd_a_idx (ra_idx),
        .rd_b_idx (rb_idx),
        .rd_a     (reg_a),
        .rd_b     (reg_b)
    );

    dotcpu_alu #(.DW(DW)) u_alu (
        .op (op),
        .a  (reg_a),
        .b  (reg_b),
        .y  (alu_y)
    );

    AST_MUL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && op == OP_MUL) |-> (reg_wdata <= DW'(MUL_MAX))); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R9

endmodule

// File: tb/tb_dotcpu_top.sv
// Scoreboard bench: expected RAM writes are queued by a driver task and
// popped by a monitor as the core writes.
module tb_dotcpu_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] data;
        string      req;
    } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rom_addr, rom_data, ram_addr, ram_wdata, ram_rdata;
    logic       ram_we, done;

    logic [7:0] rom [256];
    logic [7:0] ram [256];
    wr_item_t   exp_q [$];
    int         n_checks = 0;
    int         n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rom_data  = rom[rom_addr];
    assign ram_rdata = ram[ram_addr];

    always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

    dotcpu_top dut (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic expect_write(input logic [7:0] a, input logic [7:0] d, input string req);
        wr_item_t it;
        it.addr = a; it.data = d; it.req = req;
        exp_q.push_back(it);
    endtask

    // Monitor: compare every RAM write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected write addr", int'(ram_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(ram_addr == it.addr && ram_wdata == it.data, it.req,
                    "write addr*256+data", int'({ram_addr, ram_wdata}),
                    int'({it.addr, it.data}));
            end
        end
    end

    function automatic logic [7:0] ins(input int op, input int ra, input int rb);
        return {4'(op), 2'(ra), 2'(rb)};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            rom[i] = 8'h00;
            ram[i] = 8'h00;
        end
    endtask

    // Dot-product program: products via subroutine at 0x20, sum in main.
    task automatic load_dot_prog();
        rom[0]  = ins(1,0,0); rom[1]  = 8'h00;   // load r0,[0]
        rom[2]  = ins(1,1,0); rom[3]  = 8'h01;   // load r1,[1]
        rom[4]  = ins(7,0,0); rom[5]  = 8'h20;   // call 0x20
        rom[6]  = ins(5,0,0);                    // push r0
        rom[7]  = ins(1,0,0); rom[8]  = 8'h02;
        rom[9]  = ins(1,1,0); rom[10] = 8'h03;
        rom[11] = ins(7,0,0); rom[12] = 8'h20;
        rom[13] = ins(6,2,0);                    // pop r2
        rom[14] = ins(3,0,2);                    // add r0,r2
        rom[15] = ins(2,0,0); rom[16] = 8'h04;   // store r0,[4]
        rom[17] = ins(0,0,0);                    // halt
        rom[32] = ins(4,0,1);                    // mul r0,r1
        rom[33] = ins(8,0,0);                    // ret
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rom_addr == 8'h00 && !ram_we && !done, "R1", "reset state {addr,we,done}",
            int'({rom_addr, ram_we, done}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_to_done(input int exp_cycles, input string req);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_cycles, req, "cycles to done", n, exp_cycles);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Program 1: (3,5).(7,2) = 29; R2 R3 R6 R7 R8 R11.
        clear_mem();
        load_dot_prog();
        ram[0] = 8'd3; ram[1] = 8'd5; ram[2] = 8'd7; ram[3] = 8'd2;
        expect_write(8'hFF, 8'h06, "R7");
        expect_write(8'hFF, 8'd15, "R6");
        expect_write(8'hFE, 8'h0D, "R7");
        expect_write(8'h04, 8'd29, "R11");
        do_reset();
        run_to_done(37, "R8");
        @(negedge clk);
        chk(ram[4] == 8'd29, "R11", "result at RAM 0x04", int'(ram[4]), 29);
        chk(exp_q.size() == 0, "R3", "missing writes", exp_q.size(), 0);

        // Program 2: upper nibbles set, low nibbles 4*6 + 15*15 = 249; R4.
        exp_q.delete();
        clear_mem();
        load_dot_prog();
        ram[0] = 8'hF4; ram[1] = 8'h36; ram[2] = 8'h9F; ram[3] = 8'h2F;
        expect_write(8'hFF, 8'h06, "R7");
        expect_write(8'hFF, 8'd24, "R4");
        expect_write(8'hFE, 8'h0D, "R7");
        expect_write(8'h04, 8'd249, "R4");
        do_reset();
        run_to_done(37, "R8");
        @(negedge clk);
        chk(ram[4] == 8'd249, "R11", "result at RAM 0x04", int'(ram[4]), 249);
        chk(exp_q.size() == 0, "R4", "missing writes", exp_q.size(), 0);

        // Program 3: no-op, LIFO stack, add wrap, halt freeze; R5 R6 R9 R10.
        exp_q.delete();
        clear_mem();
        ram[0] = 8'hC8; ram[1] = 8'h5A;
        rom[0]  = ins(1,0,0); rom[1]  = 8'h00;
        rom[2]  = ins(1,1,0); rom[3]  = 8'h01;
        rom[4]  = 8'hF0;                          // undefined opcode
        rom[5]  = ins(5,0,0);                     // push r0
        rom[6]  = ins(5,1,0);                     // push r1
        rom[7]  = ins(6,2,0);                     // pop r2
        rom[8]  = ins(6,3,0);                     // pop r3
        rom[9]  = ins(2,2,0); rom[10] = 8'h08;
        rom[11] = ins(2,3,0); rom[12] = 8'h09;
        rom[13] = ins(3,2,3);                     // add r2,r3
        rom[14] = ins(2,2,0); rom[15] = 8'h0A;
        rom[16] = ins(0,0,0);
        expect_write(8'hFF, 8'hC8, "R10");
        expect_write(8'hFE, 8'h5A, "R6");
        expect_write(8'h08, 8'h5A, "R6");
        expect_write(8'h09, 8'hC8, "R6");
        expect_write(8'h0A, 8'h22, "R5");
        do_reset();
        run_to_done(29, "R10");
        chk(rom_addr == 8'd17, "R9", "PC after halt", int'(rom_addr), 17);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(rom_addr == 8'd17 && done && !ram_we, "R9", "halt frozen {pc,done,we}",
                int'({rom_addr, done, ram_we}), int'({8'd17, 1'b1, 1'b0}));
        end
        chk(exp_q.size() == 0, "R6", "missing writes", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule